// File: doc/BRIEF.md
# Segmented Program Address and Load Controller

This block produces the 8-bit program-memory address for a small nibble-wide processor and owns the program store. A 4-bit segment register forms the upper half of the address and a 4-bit program counter the lower half. The program counter only counts or clears, and has no load path. A jump therefore changes the segment and restarts at word 0 of that segment. When the counter passes word 15 it wraps to word 0 of the same segment. The sequencer tells the block when to capture the current address into the fetch latch. The latch then holds that address for the whole execute phase. Counter or segment changes made during execute show up only at the following fetch.

The block also holds two 256 x 4 memories, one for instruction nibbles and one for data nibbles. A mode selector picks between program, reset and run. In program mode the processor is held in reset and the memories are addressed from a set of switches. A debounced push button writes the switch instruction and data nibbles into both memories at that address. In run mode the instruction nibble at the latched address is always presented to the sequencer. The data nibble reaches the bus only while the sequencer asks for it.

Top module: `pgm_addr_unit`

## Requirements
- R1: `addr_out` in run mode equals the last captured value of {segment, counter}, segment in bits 7:4 and counter in bits 3:0; the counter wraps from 15 to 0 without changing the segment.
- R2: In run mode, `pc_step` high at a clock edge increments the counter by one, unless a clear occurs in the same cycle.
- R3: `restart` or `seg_load` high at a clock edge clears the counter to 0, and this clear takes priority over `pc_step`.
- R4: The segment register takes `acc_val` on an edge where `seg_load` is high, and keeps its value otherwise.
- R5: `fetch_latch` high at an edge captures {segment, counter} as they were before that edge; without it the captured address holds.
- R6: While the processor is held (reset, program or unused mode, or `rst`), the counter, segment and captured address are 0 and `cpu_hold` is 1; in program mode `addr_out` equals `sw_addr`.
- R7: The button passes a two-flop synchronizer and must read high for DEB_CYCLES consecutive cycles. Each accepted press writes `sw_instr` and `sw_data` at `sw_addr` once. A press is honoured only in program mode, and shorter pulses are ignored.
- R8: Mode code 2'b00 is reset, 2'b01 run, 2'b10 program and 2'b11 behaves as reset. A direct request between run and program passes through one cycle of reset first.
- R9: `instr_out` always shows the instruction memory at `addr_out`. `data_bus` shows the data memory at `addr_out` only when `data_oe` is high in run mode, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode request: 00 reset, 01 run, 10 program, 11 reset |
| fetch_latch | input | 1 | Capture {segment, counter} into the fetch latch |
| pc_step | input | 1 | Advance the program counter |
| restart | input | 1 | Clear the program counter |
| seg_load | input | 1 | Flag-qualified segment load; also clears the counter |
| acc_val | input | 4 | Accumulator value used as the new segment |
| data_oe | input | 1 | Request the data nibble on the bus |
| sw_addr | input | 8 | Switch address used in program mode |
| sw_instr | input | 4 | Switch instruction nibble to write |
| sw_data | input | 4 | Switch data nibble to write |
| wr_button | input | 1 | Raw write push button |
| addr_out | output | 8 | Address applied to both memories |
| instr_out | output | 4 | Instruction nibble toward the sequencer |
| data_bus | output | 4 | Data nibble when requested, else 0 |
| cpu_hold | output | 1 | High while the processor is held in reset |

## Verification
On every cycle, assertions check the following rules:
- the counter stepping and clearing;
- the clear taking priority;
- the segment holding between loads;
- the captured address holding between fetches;
- everything being zero while held;
- run and program never following one another directly.

Only the bench scenarios can show the rest. These cover:
- that a press really lands in both memories at the switch address;
- that short pulses and presses made in run mode leave the memories unchanged;
- that the fetched address sequence follows the counter across a wrap and across a segment jump, with the new segment visible only after the next fetch.

// File: rtl/pau_pkg.sv
package pau_pkg;
    localparam int PC_W   = 4;
    localparam int SEG_W  = 4;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = PC_W + SEG_W;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_RUN   = 2'b01,
        MD_LOAD  = 2'b10,
        MD_SPARE = 2'b11
    } mode_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [PC_W-1:0]  pc;
    } paddr_t;

    // A direct swap between run and program is forced through reset.
    function automatic mode_e mode_step(input mode_e cur, input logic [1:0] req);
        mode_e want;
        case (req)
            2'b01:   want = MD_RUN;
            2'b10:   want = MD_LOAD;
            default: want = MD_IDLE;
        endcase
        if ((cur == MD_RUN && want == MD_LOAD) || (cur == MD_LOAD && want == MD_RUN))
            return MD_IDLE;
        return want;
    endfunction
endpackage

// File: rtl/pau_debounce.sv
module pau_debounce #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);

    logic [1:0]       sync_q;
    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;
    logic             settle;

    assign settle = (sync_q[1] != stable_q) && (cnt_q == CNT_W'(DEB_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], btn_raw};
            press  <= settle && sync_q[1];
            if (sync_q[1] == stable_q) begin
                cnt_q <= '0;
            end else if (settle) begin
                stable_q <= sync_q[1];
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pau_nib_ram.sv
module pau_nib_ram #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pau_addr_gen.sv
module pau_addr_gen
    import pau_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             fetch_latch,
    input  logic             pc_step,
    input  logic             restart,
    input  logic             seg_load,
    input  logic [SEG_W-1:0] acc_val,
    output paddr_t           addr_q
);
    logic [PC_W-1:0]  pc_q;
    logic [SEG_W-1:0] seg_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pc_q   <= '0;
            seg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (fetch_latch) addr_q <= '{seg: seg_q, pc: pc_q};
            if (restart || seg_load) pc_q <= '0;
            else if (pc_step)        pc_q <= pc_q + 1'b1;
            if (seg_load) seg_q <= acc_val;
        end
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!hold && pc_step && !restart && !seg_load) |=> (pc_q == $past(pc_q) + 1'b1));
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (!hold && (restart || seg_load)) |=> (pc_q == '0));
    a_r4_seg_holds: assert property (@(posedge clk) disable iff (rst)
        (!hold && !seg_load) |=> $stable(seg_q));
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (!hold && !fetch_latch) |=> $stable(addr_q));
    a_r6_held_zero: assert property (@(posedge clk) disable iff (rst)
        hold |=> (pc_q == '0 && seg_q == '0 && addr_q == '0));
endmodule

// File: rtl/pgm_addr_unit.sv
module pgm_addr_unit
    import pau_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              fetch_latch,
    input  logic              pc_step,
    input  logic              restart,
    input  logic              seg_load,
    input  logic [SEG_W-1:0]  acc_val,
    input  logic              data_oe,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [NIB_W-1:0]  sw_instr,
    input  logic [NIB_W-1:0]  sw_data,
    input  logic              wr_button,
    output logic [ADDR_W-1:0] addr_out,
    output logic [NIB_W-1:0]  instr_out,
    output logic [NIB_W-1:0]  data_bus,
    output logic              cpu_hold
);
    mode_e         mode_q;
    logic          in_run, in_load, press, wr_en;
    paddr_t        latched;
    logic [NIB_W-1:0] data_rd;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_IDLE;
        else     mode_q <= mode_step(mode_q, mode_sel);
    end

    assign in_run   = (mode_q == MD_RUN);
    assign in_load  = (mode_q == MD_LOAD);
    assign cpu_hold = rst || !in_run;
    assign wr_en    = press && in_load;

    pau_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst(rst), .btn_raw(wr_button), .press(press)
    );

    pau_addr_gen u_gen (
        .clk(clk), .rst(rst), .hold(!in_run),
        .fetch_latch(fetch_latch), .pc_step(pc_step), .restart(restart),
        .seg_load(seg_load), .acc_val(acc_val), .addr_q(latched)
    );

    assign addr_out = in_load ? sw_addr : latched;

    pau_nib_ram #(.AW(ADDR_W), .DW(NIB_W)) u_iram (
        .clk(clk), .we(wr_en), .waddr(sw_addr), .wdata(sw_instr),
        .raddr(addr_out), .rdata(instr_out)
    );

    pau_nib_ram #(.AW(ADDR_W), .DW(NIB_W)) u_dram (
        .clk(clk), .we(wr_en), .waddr(sw_addr), .wdata(sw_data),
        .raddr(addr_out), .rdata(data_rd)
    );

    assign data_bus = (in_run && data_oe) ? data_rd : '0;

    a_r8_run_not_to_load: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_RUN) |=> (mode_q != MD_LOAD));
    a_r8_load_not_to_run: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_LOAD) |=> (mode_q != MD_RUN));
endmodule

// File: tb/sim_pgm_addr_unit.sv
module sim_pgm_addr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DEB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       fetch_latch = 0, pc_step = 0, restart = 0, seg_load = 0, data_oe = 0;
    logic [3:0] acc_val = 0, sw_instr = 0, sw_data = 0;
    logic [7:0] sw_addr = 0;
    logic       wr_button = 0;
    logic [7:0] addr_out;
    logic [3:0] instr_out, data_bus;
    logic       cpu_hold;

    int checks = 0, fails = 0;
    logic [3:0] m_pc = 0, m_seg = 0;
    logic [7:0] m_aq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_addr_unit #(.DEB_CYCLES(DEB)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .fetch_latch(fetch_latch),
        .pc_step(pc_step), .restart(restart), .seg_load(seg_load), .acc_val(acc_val),
        .data_oe(data_oe), .sw_addr(sw_addr), .sw_instr(sw_instr), .sw_data(sw_data),
        .wr_button(wr_button), .addr_out(addr_out), .instr_out(instr_out),
        .data_bus(data_bus), .cpu_hold(cpu_hold)
    );

    function automatic logic [3:0] fi(input logic [7:0] a);
        return 4'((a * 7 + 3) & 15);
    endfunction
    function automatic logic [3:0] fd(input logic [7:0] a);
        return 4'(((a * 11) ^ 5) & 15);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic press(input int n_hi);
        wr_button = 1'b1;
        repeat (n_hi) tick();
        wr_button = 1'b0;
        repeat (DEB + 6) tick();
    endtask

    // One run-mode cycle: apply controls, advance the bench model, compare.
    task automatic cyc(input string tag, input logic f, input logic s, input logic r,
                       input logic l, input logic [3:0] acc, input logic oe);
        fetch_latch = f; pc_step = s; restart = r; seg_load = l; acc_val = acc; data_oe = oe;
        tick();
        if (f) m_aq = {m_seg, m_pc};
        if (r || l) m_pc = 0;
        else if (s) m_pc = m_pc + 1;
        if (l) m_seg = acc;
        chk({tag, " addr"}, addr_out, m_aq);
        chk("R9 instr", instr_out, fi(m_aq));
        chk("R9 data", data_bus, oe ? fd(m_aq) : 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) tick();
        chk("R6 reset hold", cpu_hold, 1);
        chk("R6 reset addr", addr_out, 0);
        chk("R9 reset bus", data_bus, 0);
        rst = 0;

        // Program mode: fill both memories.
        mode_sel = 2'b10;
        sw_addr = 8'h9C;
        tick();
        chk("R6 prog hold", cpu_hold, 1);
        chk("R6 prog addr", addr_out, 8'h9C);
        for (int a = 0; a < 256; a++) begin
            sw_addr = 8'(a); sw_instr = fi(8'(a)); sw_data = fd(8'(a));
            press(DEB + 3);
        end
        for (int a = 0; a < 256; a++) begin
            sw_addr = 8'(a); #1;
            chk("R7 readback", instr_out, fi(8'(a)));
        end
        // Short pulse must not write.
        sw_addr = 8'h33; sw_instr = ~fi(8'h33);
        press(DEB - 2);
        chk("R7 short pulse ignored", instr_out, fi(8'h33));

        // Direct program -> run passes through reset.
        mode_sel = 2'b01;
        tick();
        chk("R8 via reset", cpu_hold, 1);
        tick();
        chk("R8 run entered", cpu_hold, 0);
        chk("R1 start addr", addr_out, 0);

        // Counter wrap inside segment 0.
        for (int i = 0; i < 17; i++) cyc("R2 step", 1, 1, 0, 0, 0, 1);
        cyc("R1 wrap", 1, 0, 0, 0, 0, 0);
        chk("R1 wrap stays in seg", addr_out, 8'h01);
        // Segment jump: visible only after the next fetch.
        cyc("R4 jump", 0, 1, 0, 1, 4'h5, 0);
        chk("R5 held after jump", addr_out, 8'h01);
        cyc("R3 fetch after jump", 1, 0, 0, 0, 0, 1);
        chk("R3 R4 new segment", addr_out, 8'h50);
        cyc("R2 step", 0, 1, 0, 0, 0, 0);
        cyc("R2 step", 0, 1, 0, 0, 0, 0);
        cyc("R3 restart priority", 0, 1, 1, 0, 0, 0);
        cyc("R3 fetch", 1, 0, 0, 0, 0, 1);
        chk("R3 restart", addr_out, 8'h50);
        cyc("R9 bus off", 0, 0, 0, 0, 0, 0);
        chk("R9 bus zero", data_bus, 0);

        // Constrained random run traffic.
        for (int i = 0; i < 3000; i++) begin
            cyc("R5 random", 1'($urandom % 3 == 0), 1'($urandom % 2),
                1'($urandom % 16 == 0), 1'($urandom % 8 == 0),
                4'($urandom), 1'($urandom % 2));
        end

        // Write attempt in run mode must be ignored.
        fetch_latch = 0; pc_step = 0; restart = 0; seg_load = 0;
        sw_addr = 8'h44; sw_instr = ~fi(8'h44); sw_data = ~fd(8'h44);
        press(DEB + 3);
        mode_sel = 2'b00; tick();
        mode_sel = 2'b10; tick();
        chk("R7 run write ignored", instr_out, fi(8'h44));

        // Unused code acts as reset; run -> program goes via reset.
        mode_sel = 2'b11; tick();
        chk("R8 code 11 hold", cpu_hold, 1);
        chk("R8 code 11 addr", addr_out, 0);
        mode_sel = 2'b01; tick();
        chk("R8 run from reset", cpu_hold, 0);
        mode_sel = 2'b10; tick();
        chk("R8 run to prog via reset", addr_out, 0);
        tick();
        chk("R6 prog addr again", addr_out, 8'h44);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule